// File: doc/BRIEF.md
# Dual-Port Latch Register File

A small storage array of four words, four bits each, with one write port and one read port that work independently. A write into one word and a read from another word can happen in the same cycle. The block is a clocked model of level-sensitive storage. A word that is being written takes new data on every clock edge for as long as the active-low write enable stays asserted.

The read path shows the selected word without inversion. When the read address matches the write address during a write, the read path takes the incoming data directly, so the reader sees the new value in the same cycle. The data outputs drive only while the active-low read enable is asserted. At all other times they float, so several copies of the block can share one bus to give more words. A plain read-data vector and a drive flag are also provided for use where floating nets are not allowed. Placing several copies side by side gives wider words.

The array is never cleared. A word holds an undefined value until it is first written. The reset input only blocks writes while it is asserted.

Top module: `latch_regfile`

## Requirements
- R1: When `wr_n` is 0 and `rst_n` is 1 at a rising clock edge, the word selected by `waddr` takes the value of `wdata`. A read of that word returns the new value from the next cycle on.
- R2: While `wr_n` stays 0 over consecutive edges with `waddr` held, the selected word follows `wdata` at every edge. After `wr_n` returns to 1, it keeps the last value taken.
- R3: At an edge where `wr_n` is 1, no stored word changes, whatever `waddr` and `wdata` carry.
- R4: `rd_data` shows the word selected by `raddr` in true, non-inverted form, in the same cycle the address is applied. This holds for any value of `wr_n` and `rd_n`.
- R5: When `rd_n` is 0, `q` equals `rd_data` and `rd_oe` is 1. When `rd_n` is 1, all four bits of `q` are high impedance and `rd_oe` is 0.
- R6: A read of one word during a write to a different word returns that word's stored value, and the write still lands.
- R7: When `wr_n` is 0, `rst_n` is 1 and `raddr` equals `waddr`, `rd_data` equals `wdata` in the same cycle, and that value is what the word holds afterwards.
- R8: `waddr` must not change between consecutive cycles in which `wr_n` is 0. This is a usage rule on the driver.
- R9: While `rst_n` is 0, no write and no write-through take place, and stored words keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Active-low reset; blocks writes only |
| wr_n | input | 1 | Active-low write enable |
| waddr | input | 2 | Destination word |
| wdata | input | 4 | Data to store |
| rd_n | input | 1 | Active-low read/output enable |
| raddr | input | 2 | Source word |
| q | output | 4 | Bus outputs, high impedance when `rd_n` is 1 |
| rd_data | output | 4 | Selected word, always driven |
| rd_oe | output | 1 | 1 while `q` drives |

## Verification
A word that held a wrong value would show on `rd_data` as soon as `raddr` selects it, because the read path has no register. Such a fault is therefore visible in the cycle the word is read. A write that went to the wrong word would show as a changed value on a word the bench did not write, on a later read. A missing bypass would show as the old value during the write cycle itself. Every combination of write address, read address and data value is swept, with writes held over many edges, so each of these faults reaches the ports within one cycle of being read.

// File: rtl/latch_regfile.sv
module latch_regfile #(
  parameter int WORDS = 4,
  parameter int WIDTH = 4,
  localparam int AW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_n,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd_n,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_oe
);

  logic wr_en;
  logic hit;
  logic [WORDS-1:0][WIDTH-1:0] mem_w;

  assign wr_en = rst_n & ~wr_n;

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic [WIDTH-1:0] word_q;
    always_ff @(posedge clk) begin
      if (wr_en && waddr == AW'(i)) word_q <= wdata;
    end
    assign mem_w[i] = word_q;
  end

  assign hit     = wr_en && (raddr == waddr);
  assign rd_data = hit ? wdata : mem_w[raddr];
  assign rd_oe   = ~rd_n;
  assign q       = rd_oe ? rd_data : {WIDTH{1'bz}};

  // R1: a write lands in the addressed word
  p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |=> mem_w[$past(waddr)] == $past(wdata));

  // R3: no change while writes are off
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n |=> $stable(mem_w));

  // R5: a driving bus carries the read data
  p_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> q == rd_data);

  // R7: the bypassed value is what the word holds afterwards
  p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && raddr == waddr) |=> mem_w[$past(raddr)] == $past(rd_data));

  // R8: write address stable across a low enable phase
  p_waddr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && $past(!wr_n) && $past(rst_n)) |-> waddr == $past(waddr));

  // R9: reset blocks writes
  p_reset_hold_r9: assert property (@(posedge clk)
    !rst_n |=> $stable(mem_w));

endmodule

// File: tb/latch_regfile_tb.sv
module latch_regfile_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_n = 1'b1;
  logic [1:0] waddr = '0;
  logic [3:0] wdata = '0;
  logic rd_n = 1'b1;
  logic [1:0] raddr = '0;
  wire  [3:0] q;
  logic [3:0] rd_data;
  logic rd_oe;

  int checks = 0;
  int failures = 0;
  logic [3:0] model [4];

  always #2 clk = ~clk;

  latch_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .waddr(waddr), .wdata(wdata),
    .rd_n(rd_n), .raddr(raddr), .q(q), .rd_data(rd_data), .rd_oe(rd_oe)
  );

  task automatic check4(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_bus(input string req);
    if (rd_n) begin
      check4({req, " q float"}, q, 4'bzzzz);
      check4({req, " oe low"}, {3'b0, rd_oe}, 4'h0);
    end else begin
      check4({req, " q drive"}, q, rd_data);
      check4({req, " oe high"}, {3'b0, rd_oe}, 4'h1);
    end
  endtask

  // apply inputs after a falling edge, check before the rising edge, update the model at it
  task automatic step(input logic w_n, input logic [1:0] wa, input logic [3:0] d,
                      input logic r_n, input logic [1:0] ra, input string req);
    logic [3:0] exp;
    wr_n = w_n; waddr = wa; wdata = d; rd_n = r_n; raddr = ra;
    #1;
    exp = (!w_n && rst_n && wa == ra) ? d : model[ra];
    check4(req, rd_data, exp);
    check_bus(req);
    @(posedge clk);
    if (!w_n && rst_n) model[wa] = d;
    @(negedge clk);
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < 4; a++) step(1'b1, 2'(3 - a), 4'hF, 1'b0, 2'(a), req);
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    check_bus("R5 reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R1: fill every word, then read each back
    for (int a = 0; a < 4; a++) begin
      step(1'b0, 2'(a), 4'(4'h9 ^ (a * 5)), 1'b1, 2'(a), "R1 R7 fill");
      step(1'b1, 2'(a), 4'h0, 1'b1, 2'(a), "R1 gap");
    end
    read_all("R1 R4 readback");

    // R2 R6 R7: hold a write over many edges, sweep read address and data
    for (int w = 0; w < 4; w++) begin
      for (int r = 0; r < 4; r++)
        for (int d = 0; d < 16; d++)
          step(1'b0, 2'(w), 4'(d), d[0], 2'(r), (w == r) ? "R7 bypass" : "R2 R6 concurrent");
      step(1'b1, 2'(w), 4'h0, 1'b0, 2'(w), "R2 last value kept");
    end
    read_all("R2 R6 after sweep");

    // R3: disabled writes with active-looking address and data
    for (int w = 0; w < 4; w++)
      for (int d = 0; d < 16; d += 5)
        step(1'b1, 2'(w), 4'(d), d[0], 2'(w), "R3 no write");
    read_all("R3 unchanged");

    // R9: write attempts under reset have no effect
    rst_n = 1'b0;
    for (int w = 0; w < 4; w++) begin
      step(1'b0, 2'(w), ~model[w], 1'b0, 2'(w), "R9 no bypass in reset");
      step(1'b1, 2'(w), 4'h0, 1'b1, 2'(w), "R9 gap");
    end
    rst_n = 1'b1;
    read_all("R9 unchanged");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule